// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software has to keep alive by writing a two-word unlock pair to a feed register at a permitted moment. A down-counter, loaded from a programmable reload value, decrements once per clock after the first accepted feed. If software lets the counter run out, or feeds it too early or with a broken key pair, the block raises a sticky fault flag. If the reset-on-fault control bit is set, it also emits a one-cycle reset request to the system reset controller. An early-warning threshold raises an interrupt before the counter runs out. A window threshold rejects feeds that arrive while the count is still above it.

Software reaches the block through a simple single-cycle register bus. Its write data and read data are as wide as the counter. Reads are combinational on the address. The control bits for enable, reset-on-fault and clock-source lock can only be set, and only a reset clears them. A protect bit, also set-only, freezes the reload value while the count is above the window. Software may set it only once the counter is running and a short settle time has passed since the last accepted feed. The clock-lock state goes out on a pin for the clock generator.

Register addresses: 0 control/status, 1 reload value, 2 feed, 3 counter value, 4 window value, 5 warning value. Control bit positions: 0 enable, 1 reset-on-fault, 2 fault flag, 3 warning flag, 4 protect, 5 clock lock.

Top module: `wdog_win_top`

## Requirements
- R1: After reset the control register reads 0, reload and window read all ones, the warning value reads 0, the counter register reads 0x0000FF, and warn_irq, rst_req and clk_lock are low.
- R2: A feed is a write of 0xAA (low 8 bits) to address 2 directly followed, on the next bus write cycle, by a write of 0x55 to address 2. When enable (bit 0) is set, it loads the counter from the reload value one cycle later. With enable clear, a feed has no effect.
- R3: The counter stays idle, reading 0x0000FF at address 3, until the first accepted feed. From then on it decrements by one each clock.
- R4: In a clock where a running counter holds zero and no feed is accepted, the fault flag (bit 2) sets and the counter reloads. If reset-on-fault (bit 1) is set, rst_req is high for exactly the following cycle.
- R5: With enable set, any bus write in the cycle right after a 0xAA feed write, other than 0x55 to address 2, is a fault with the same flag and reset request as R4. The counter keeps counting without a reload.
- R6: A completed feed while the running count is above the window value is a fault (as in R4) and does not reload the counter. With the window at all ones, a feed is accepted at any count.
- R7: When a running count equals a nonzero warning value, the warning flag (bit 3) sets on the next edge and warn_irq follows it. A warning value of 0 disables the warning.
- R8: Writing 0 to bit 2 of the control register clears the fault flag. Writing 1 leaves it unchanged.
- R9: Writing 1 to bit 3 clears the warning flag. Writing 0 leaves it unchanged.
- R10: Enable, reset-on-fault and clock lock (bit 5, also driven on clk_lock) are set by writing 1. Writing 0 never clears them.
- R11: Protect (bit 4) is set only by a write made while the counter runs and at least PROT_DLY clocks after the last accepted feed. Only reset clears it. While it is set, a reload-value write is ignored unless the count is at or below the window value.
- R12: A feed accepted in the same clock in which the count is zero reloads the counter without a fault. A fault raised in the same clock as a control write that clears the fault flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| warn_irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request |
| clk_lock | output | 1 | Clock-source lock state |

## Verification
Two events can land in the same clock: the counter reaching zero, and a write that either completes a feed or clears the fault flag. The bench places the 0x55 key write exactly in the cycle where the count reads zero, and places a flag-clearing control write in the cycle where the timeout fires. It then reads the count, the flag and rst_req in the next cycle. A behavioural model that steps each clock judges every cycle, and explicit expectations worked out from the requirements back it up.

// File: rtl/wdog_win_pkg.sv
package wdog_win_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL   = 3'd0,
      RA_RELOAD = 3'd1,
      RA_FEED   = 3'd2,
      RA_COUNT  = 3'd3,
      RA_WINDOW = 3'd4,
      RA_WARN   = 3'd5
   } reg_addr_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] IDLE_VALUE = 8'hFF;

   localparam int unsigned CB_EN    = 0;
   localparam int unsigned CB_RSTEN = 1;
   localparam int unsigned CB_FAULT = 2;
   localparam int unsigned CB_WARN  = 3;
   localparam int unsigned CB_PROT  = 4;
   localparam int unsigned CB_LOCK  = 5;
   localparam int unsigned CB_NUM   = 6;

endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
   import wdog_win_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [7:0]        key,
   output logic              feed_ok,
   output logic              seq_err
);

   logic armed_q;
   logic is_feed;

   always_comb begin
      is_feed = wr && (reg_addr_e'(addr) == RA_FEED);
      feed_ok = armed_q && is_feed && (key == KEY_SECOND);
      seq_err = armed_q && wr && !feed_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= !armed_q && is_feed && (key == KEY_FIRST);
   end

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
   parameter int unsigned CNT_W    = 24,
   parameter int unsigned WARN_W   = 10,
   parameter int unsigned PROT_DLY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              feed_ok,
   input  logic [CNT_W-1:0]  reload,
   input  logic [CNT_W-1:0]  window,
   input  logic [WARN_W-1:0] warn,
   output logic              run,
   output logic [CNT_W-1:0]  cnt,
   output logic              win_err,
   output logic              tout_ev,
   output logic              warn_ev,
   output logic              prot_ok
);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             accept;
   logic             good_feed;

   always_comb begin
      accept    = feed_ok && en;
      win_err   = accept && run_q && (cnt_q > window);
      good_feed = accept && !win_err;
      tout_ev   = run_q && !good_feed && (cnt_q == '0);
      warn_ev   = run_q && !good_feed && (warn != '0) && (cnt_q == CNT_W'(warn));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '1;
      end else if (good_feed) begin
         run_q <= 1'b1;
         cnt_q <= reload;
      end else if (run_q) begin
         cnt_q <= tout_ev ? reload : cnt_q - 1'b1;
      end
   end

   generate
      if (PROT_DLY == 0) begin : g_prot_nodly
         assign prot_ok = run_q;
      end else begin : g_prot_dly
         localparam int unsigned SW = $clog2(PROT_DLY + 1);
         logic [SW-1:0] since_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         since_q <= '0;
            else if (good_feed)                 since_q <= '0;
            else if (since_q != SW'(PROT_DLY))  since_q <= since_q + 1'b1;
         end
         assign prot_ok = run_q && (since_q == SW'(PROT_DLY));
      end
   endgenerate

   assign run = run_q;
   assign cnt = cnt_q;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_win_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned WARN_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              run,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              tout_ev,
   input  logic              warn_ev,
   input  logic              fault,
   input  logic              prot_ok,
   output logic              en,
   output logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  window,
   output logic [WARN_W-1:0] warn,
   output logic [CNT_W-1:0]  rdata,
   output logic              warn_irq,
   output logic              rst_req,
   output logic              clk_lock
);

   logic              en_q, rsten_q, fault_q, warnf_q, prot_q, lock_q, rst_req_q;
   logic [CNT_W-1:0]  reload_q, window_q;
   logic [WARN_W-1:0] warn_q;
   logic              ctrl_wr, reload_wr, window_wr, warn_wr, reload_ok;
   logic [CB_NUM-1:0] ctrl_rd;

   always_comb begin
      ctrl_wr   = wr && (reg_addr_e'(addr) == RA_CTRL);
      reload_wr = wr && (reg_addr_e'(addr) == RA_RELOAD);
      window_wr = wr && (reg_addr_e'(addr) == RA_WINDOW);
      warn_wr   = wr && (reg_addr_e'(addr) == RA_WARN);
      reload_ok = !prot_q || (run && (cnt <= window_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         rsten_q   <= 1'b0;
         fault_q   <= 1'b0;
         warnf_q   <= 1'b0;
         prot_q    <= 1'b0;
         lock_q    <= 1'b0;
         rst_req_q <= 1'b0;
         reload_q  <= '1;
         window_q  <= '1;
         warn_q    <= '0;
      end else begin
         rst_req_q <= (tout_ev || fault) && rsten_q;
         if (ctrl_wr) begin
            en_q    <= en_q    | wdata[CB_EN];
            rsten_q <= rsten_q | wdata[CB_RSTEN];
            lock_q  <= lock_q  | wdata[CB_LOCK];
            if (wdata[CB_PROT] && prot_ok) prot_q <= 1'b1;
         end
         if (tout_ev || fault)                fault_q <= 1'b1;
         else if (ctrl_wr && !wdata[CB_FAULT]) fault_q <= 1'b0;
         if (warn_ev)                         warnf_q <= 1'b1;
         else if (ctrl_wr && wdata[CB_WARN])  warnf_q <= 1'b0;
         if (reload_wr && reload_ok) reload_q <= wdata;
         if (window_wr)              window_q <= wdata;
         if (warn_wr)                warn_q   <= wdata[WARN_W-1:0];
      end
   end

   always_comb begin
      ctrl_rd           = '0;
      ctrl_rd[CB_EN]    = en_q;
      ctrl_rd[CB_RSTEN] = rsten_q;
      ctrl_rd[CB_FAULT] = fault_q;
      ctrl_rd[CB_WARN]  = warnf_q;
      ctrl_rd[CB_PROT]  = prot_q;
      ctrl_rd[CB_LOCK]  = lock_q;
      case (reg_addr_e'(addr))
         RA_CTRL:   rdata = CNT_W'(ctrl_rd);
         RA_RELOAD: rdata = reload_q;
         RA_COUNT:  rdata = run ? cnt : CNT_W'(IDLE_VALUE);
         RA_WINDOW: rdata = window_q;
         RA_WARN:   rdata = CNT_W'(warn_q);
         default:   rdata = '0;
      endcase
   end

   assign en       = en_q;
   assign reload   = reload_q;
   assign window   = window_q;
   assign warn     = warn_q;
   assign warn_irq = warnf_q;
   assign rst_req  = rst_req_q;
   assign clk_lock = lock_q;

endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
   import wdog_win_pkg::*;
#(
   parameter int unsigned CNT_W    = 24,
   parameter int unsigned WARN_W   = 10,
   parameter int unsigned PROT_DLY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              warn_irq,
   output logic              rst_req,
   output logic              clk_lock
);

   generate
      if (CNT_W < 8) begin : g_bad_cnt_w
         $error("CNT_W must hold the 8-bit feed keys");
      end
      if (WARN_W < 1 || WARN_W > CNT_W) begin : g_bad_warn_w
         $error("WARN_W must lie between 1 and CNT_W");
      end
   endgenerate

   logic              feed_ok_w, seq_err_w, en_w, run_w;
   logic              win_err_w, tout_ev_w, warn_ev_w, prot_ok_w, fault_w;
   logic [CNT_W-1:0]  cnt_w, reload_w, window_w;
   logic [WARN_W-1:0] warn_w;

   wdog_feed_seq u_feed (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .key     (bus_wdata[7:0]),
      .feed_ok (feed_ok_w),
      .seq_err (seq_err_w)
   );

   wdog_cnt #(.CNT_W(CNT_W), .WARN_W(WARN_W), .PROT_DLY(PROT_DLY)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_w),
      .feed_ok (feed_ok_w),
      .reload  (reload_w),
      .window  (window_w),
      .warn    (warn_w),
      .run     (run_w),
      .cnt     (cnt_w),
      .win_err (win_err_w),
      .tout_ev (tout_ev_w),
      .warn_ev (warn_ev_w),
      .prot_ok (prot_ok_w)
   );

   assign fault_w = (seq_err_w && en_w) || win_err_w;

   wdog_regs #(.CNT_W(CNT_W), .WARN_W(WARN_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .run      (run_w),
      .cnt      (cnt_w),
      .tout_ev  (tout_ev_w),
      .warn_ev  (warn_ev_w),
      .fault    (fault_w),
      .prot_ok  (prot_ok_w),
      .en       (en_w),
      .reload   (reload_w),
      .window   (window_w),
      .warn     (warn_w),
      .rdata    (bus_rdata),
      .warn_irq (warn_irq),
      .rst_req  (rst_req),
      .clk_lock (clk_lock)
   );

endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned WARN_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              warn_irq,
   input logic              clk_lock,
   input logic              en,
   input logic              feed_ok,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  reload,
   input logic [WARN_W-1:0] warn
);

   // R3: idle counter holds its reset value until started
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (cnt == '1));

   // R3: running counter steps down by one when nothing intervenes
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cnt != '0) && !(feed_ok && en)) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   // R4: expiry reloads from the reload value
   assert_expiry_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cnt == '0) && !(feed_ok && en)) |=> (cnt == $past(reload)));

   // R7: warning rises only after the count matched the threshold
   assert_warn_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_irq) |-> ($past(cnt) == CNT_W'($past(warn))));

   // R10: set-only bits never fall
   assert_en_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(en));

   assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(clk_lock));

endmodule

bind wdog_win_top wdog_win_chk #(.CNT_W(CNT_W), .WARN_W(WARN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .warn_irq (warn_irq),
   .clk_lock (clk_lock),
   .en       (en_w),
   .feed_ok  (feed_ok_w),
   .run      (run_w),
   .cnt      (cnt_w),
   .reload   (reload_w),
   .warn     (warn_w)
);

// File: tb/wdog_win_top_tb_top.sv
`timescale 1ns/100ps
module wdog_win_top_tb_top;

   localparam int CW = 24;
   localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_FEED = 3'd2,
                          A_COUNT = 3'd3, A_WINDOW = 3'd4, A_WARN = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = 3'd0;
   logic [CW-1:0] bus_wdata = '0;
   logic [CW-1:0] bus_rdata;
   logic          warn_irq, rst_req, clk_lock;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   always #2 clk = ~clk;

   wdog_win_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .warn_irq(warn_irq),
      .rst_req(rst_req), .clk_lock(clk_lock)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_en, m_rsten, m_fault, m_warnf, m_prot, m_lock, m_rstreq;
   bit          m_run, m_armed;
   logic [23:0] m_reload, m_window, m_cnt;
   logic [9:0]  m_warnv;
   int          m_since;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_rsten = 0; m_fault = 0; m_warnf = 0; m_prot = 0; m_lock = 0;
         m_rstreq = 0; m_run = 0; m_armed = 0; m_since = 0;
         m_reload = 24'hFFFFFF; m_window = 24'hFFFFFF; m_cnt = 24'hFFFFFF; m_warnv = 0;
      end else begin
         bit key_wr, pair_done, broken, took, too_early, fed, expired, warned, fault, may_protect, may_reload;
         key_wr      = bus_wr && bus_addr == A_FEED;
         pair_done   = m_armed && key_wr && bus_wdata[7:0] == 8'h55;
         broken      = m_armed && bus_wr && !pair_done;
         took        = pair_done && m_en;
         too_early   = took && m_run && (m_cnt > m_window);
         fed         = took && !too_early;
         expired     = m_run && !fed && m_cnt == 0;
         warned      = m_run && !fed && m_warnv != 0 && m_cnt == 24'(m_warnv);
         fault       = (broken && m_en) || too_early;
         may_protect = m_run && m_since >= 3;
         may_reload  = !m_prot || (m_run && m_cnt <= m_window);
         m_rstreq = (expired || fault) && m_rsten;
         if (bus_wr && bus_addr == A_CTRL) begin
            if (bus_wdata[0]) m_en = 1;
            if (bus_wdata[1]) m_rsten = 1;
            if (bus_wdata[5]) m_lock = 1;
            if (bus_wdata[4] && may_protect) m_prot = 1;
            if (!bus_wdata[2]) m_fault = 0;
            if (bus_wdata[3]) m_warnf = 0;
         end
         if (expired || fault) m_fault = 1;
         if (warned) m_warnf = 1;
         if (bus_wr && bus_addr == A_RELOAD && may_reload) m_reload = bus_wdata;
         if (bus_wr && bus_addr == A_WINDOW) m_window = bus_wdata;
         if (bus_wr && bus_addr == A_WARN) m_warnv = bus_wdata[9:0];
         if (fed) begin
            m_run = 1; m_cnt = m_reload_prev(); m_since = 0;
         end else begin
            if (m_since < 3) m_since++;
            if (m_run) m_cnt = expired ? m_reload_prev() : m_cnt - 1;
         end
         m_armed = !m_armed && key_wr && bus_wdata[7:0] == 8'hAA;
         m_reload_old = m_reload;
      end
   end

   // reload value as it stood before this edge's register write
   logic [23:0] m_reload_old = 24'hFFFFFF;
   function automatic logic [23:0] m_reload_prev();
      return m_reload_old;
   endfunction

   function automatic logic [23:0] model_read(logic [2:0] a);
      case (a)
         A_CTRL:   return {18'd0, m_lock, m_prot, m_warnf, m_fault, m_rsten, m_en};
         A_RELOAD: return m_reload;
         A_COUNT:  return m_run ? m_cnt : 24'h0000FF;
         A_WINDOW: return m_window;
         A_WARN:   return {14'd0, m_warnv};
         default:  return 24'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(bus_addr == A_COUNT ? "R3 model" : "R8/R9 model", 32'(bus_rdata), 32'(model_read(bus_addr)));
         chk("R7 model", 32'(warn_irq), 32'(m_warnf));
         chk("R4 model", 32'(rst_req), 32'(m_rstreq));
         chk("R10 model", 32'(clk_lock), 32'(m_lock));
      end
   end

   // ---------------- stimulus helpers: one call = one cycle ----------------
   task automatic wr(input logic [2:0] a, input logic [23:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input logic [2:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         bus_wr = 1'b0; bus_addr = a;
      end
   endtask

   task automatic peek(input logic [2:0] a, input logic [23:0] exp, input string req);
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = a;
      #0.5;
      chk(req, 32'(bus_rdata), 32'(exp));
   endtask

   task automatic feed();
      wr(A_FEED, 24'hAA);
      wr(A_FEED, 24'h55);
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset state
      peek(A_CTRL, 24'h0, "R1 ctrl");
      chk("R1 warn_irq", 32'(warn_irq), 0);
      chk("R1 rst_req", 32'(rst_req), 0);
      chk("R1 clk_lock", 32'(clk_lock), 0);
      peek(A_RELOAD, 24'hFFFFFF, "R1 reload");
      peek(A_WINDOW, 24'hFFFFFF, "R1 window");
      peek(A_WARN, 24'h0, "R1 warn");
      peek(A_COUNT, 24'h0000FF, "R1 count");

      // R2 feed ignored while disabled
      feed();
      peek(A_COUNT, 24'h0000FF, "R2 disabled feed");
      wr(A_RELOAD, 24'd40);
      wr(A_CTRL, 24'h03);
      idle(A_COUNT, 4);
      peek(A_COUNT, 24'h0000FF, "R3 not started");

      // R2/R3/R4 start, count down, expire
      feed();
      peek(A_COUNT, 24'd40, "R2 reload");
      peek(A_COUNT, 24'd39, "R3 decrement");
      idle(A_COUNT, 38);
      peek(A_COUNT, 24'd0, "R4 zero");
      peek(A_CTRL, 24'h07, "R4 fault flag");
      chk("R4 rst_req pulse", 32'(rst_req), 1);
      peek(A_COUNT, 24'd39, "R4 reloaded");
      chk("R4 rst_req single", 32'(rst_req), 0);

      // R8 fault flag clear by zero; R10 sticky bits
      wr(A_CTRL, 24'h07);
      peek(A_CTRL, 24'h07, "R8 write one keeps");
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h03, "R8 cleared, R10 enable kept");
      wr(A_CTRL, 24'h20);
      peek(A_CTRL, 24'h23, "R10 lock set");
      chk("R10 clk_lock pin", 32'(clk_lock), 1);
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h23, "R10 lock sticky");

      // R7 warning, R9 warning clear by one
      wr(A_WARN, 24'd10);
      feed();
      idle(A_CTRL, 30);
      peek(A_CTRL, 24'h23, "R7 before match");
      peek(A_CTRL, 24'h2B, "R7 warning flag");
      chk("R7 warn_irq", 32'(warn_irq), 1);
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h2B, "R9 write zero keeps");
      wr(A_CTRL, 24'h08);
      peek(A_CTRL, 24'h23, "R9 cleared");
      chk("R9 warn_irq low", 32'(warn_irq), 0);
      wr(A_WARN, 24'd0);
      feed();

      // R12 feed in the zero cycle
      idle(A_COUNT, 39);
      wr(A_FEED, 24'hAA);
      wr(A_FEED, 24'h55);
      peek(A_COUNT, 24'd40, "R12 feed at zero reloads");
      chk("R12 no reset request", 32'(rst_req), 0);
      peek(A_CTRL, 24'h23, "R12 no fault");

      // R12 fault beats clear
      feed();
      idle(A_COUNT, 40);
      wr(A_CTRL, 24'h23);
      peek(A_CTRL, 24'h27, "R12 set wins over clear");
      chk("R12 rst_req", 32'(rst_req), 1);
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h23, "R8 clear after collision");

      // R6 window
      feed();
      wr(A_WINDOW, 24'd20);
      idle(A_COUNT, 8);
      wr(A_FEED, 24'hAA);
      wr(A_FEED, 24'h55);
      peek(A_COUNT, 24'd29, "R6 early feed no reload");
      chk("R6 rst_req", 32'(rst_req), 1);
      peek(A_CTRL, 24'h27, "R6 fault flag");
      wr(A_CTRL, 24'h00);
      idle(A_COUNT, 5);
      wr(A_FEED, 24'hAA);
      wr(A_FEED, 24'h55);
      peek(A_COUNT, 24'd40, "R6 feed inside window");
      chk("R6 no rst_req", 32'(rst_req), 0);
      peek(A_CTRL, 24'h23, "R6 no fault");
      wr(A_WINDOW, 24'hFFFFFF);

      // R5 broken key pair
      feed();
      wr(A_FEED, 24'hAA);
      wr(A_FEED, 24'h12);
      peek(A_COUNT, 24'd38, "R5 no reload");
      chk("R5 rst_req", 32'(rst_req), 1);
      peek(A_CTRL, 24'h27, "R5 fault flag");
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h23, "R5 cleared");

      // R11 protect
      feed();
      wr(A_CTRL, 24'h10);
      peek(A_CTRL, 24'h23, "R11 protect too soon");
      idle(A_CTRL, 3);
      wr(A_CTRL, 24'h10);
      peek(A_CTRL, 24'h33, "R11 protect set");
      wr(A_WINDOW, 24'd20);
      wr(A_RELOAD, 24'd50);
      peek(A_RELOAD, 24'd40, "R11 reload locked above window");
      idle(A_COUNT, 10);
      wr(A_RELOAD, 24'd50);
      peek(A_RELOAD, 24'd50, "R11 reload allowed in window");
      feed();
      peek(A_COUNT, 24'd50, "R11 new reload used");
      wr(A_CTRL, 24'h00);
      peek(A_CTRL, 24'h33, "R11 protect sticky");

      idle(A_CTRL, 2);
      report();
   end

endmodule